// File: doc/BRIEF.md
# Quad Up-Counting Timer Bank

This block holds four identical 16-bit up-counters behind one small register port. Each counter advances on a shared tick strobe while counting is enabled. It can raise an event when the incremented value matches a compare value, or when the counter wraps past its all-ones value. An event drives a one-cycle pulse on that timer's interrupt line and sets a sticky status flag, and it can optionally return the counter to zero. Timer 0 stays armed after an event, so it suits a periodic system tick. Timers 1 to 3 disarm their compare after one event and act as single-shot delays.

Software reaches the timers through a single-cycle port. Read data is combinational from the address. A write takes effect at the clock edge on which the write enable is high. Each timer occupies a 0x800-byte window. Only the two lowest timers carry a general-purpose hold register.

Top module: `tmr_quad`

## Requirements
- R1: The timer is chosen by address bits [12:11] (bases 0x0000, 0x0800, 0x1000, 0x1800). The register is chosen by bits [5:4]: 0 count, 1 mode, 2 compare, 3 hold. Bits [10:6] and [3:0] must be zero; any other address reads 0 and ignores writes.
- R2: After a synchronous active-low reset, every register reads 0 and all interrupt lines are low.
- R3: Mode bit 0 enables counting. Each tick strobe adds one while it is set, and the count holds while it is clear.
- R4: A write to a timer's count register loads that value. A write to its count or mode register in the same cycle as a tick takes priority, and that timer skips that tick.
- R5: With mode bit 2 set, a compare event occurs on a counted tick whose incremented value equals the compare register.
- R6: With mode bit 3 set, an overflow event occurs on a counted tick taken while the count is 0xFFFF; the count wraps to 0.
- R7: An event drives the timer's irq line high for exactly the one clock that follows the edge taking the tick. It sets mode bit 10 for a compare event and mode bit 11 for an overflow event.
- R8: With mode bit 1 (zero-return) set, the counter becomes 0 on an event instead of the incremented value.
- R9: After an event, timers 1 to 3 clear mode bit 2 and mode bit 11. Timer 0 keeps both, so it fires again on its next match.
- R10: Timers 0 and 1 have a read/write hold register. For timers 2 and 3, the hold offset reads 0 and ignores writes.
- R11: A mode write loads bits [3:0]. Writing 1 to bit 10 or bit 11 clears that flag, and writing 0 leaves it unchanged. All other mode bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Count strobe common to all timers |
| bus_addr_i | input | 13 | Register byte address |
| bus_wdata_i | input | 16 | Write data |
| bus_we_i | input | 1 | Write enable, one cycle per write |
| bus_rdata_o | output | 16 | Combinational read data for bus_addr_i |
| irq_o | output | 4 | Per-timer event pulse |

## Verification
The assertions assume that the tick strobe and write enable are clean, synchronous levels sampled only at rising edges. They also assume the design is reset before the first access. The stimulus therefore changes every input on the falling edge and holds reset low for several cycles at the start. The assertions relate an interrupt pulse to a counted tick one cycle earlier. They also assume that no mode write lands in the same cycle as an event, which holds because such a write suppresses the tick. The bench keeps that case to one directed check and otherwise separates writes from ticks.

// File: rtl/tmr_pkg.sv
// Package: shared sizes and mode-bit positions for the quad timer bank.
// Assumes a 16-bit data path and a 0x800-byte window per timer.
package tmr_pkg;
    localparam int DW        = 16;
    localparam int STRIDE_LSB = 11;
    localparam int NUM_TMR   = 4;
    localparam int TIDX_W    = $clog2(NUM_TMR);
    localparam int AW        = STRIDE_LSB + TIDX_W;

    // Mode register bit positions
    localparam int M_RUN  = 0;
    localparam int M_ZRET = 1;
    localparam int M_CMPE = 2;
    localparam int M_OVFE = 3;
    localparam int M_CFLG = 10;
    localparam int M_OFLG = 11;

    typedef enum logic [1:0] {
        RG_COUNT = 2'd0,
        RG_MODE  = 2'd1,
        RG_CMP   = 2'd2,
        RG_HOLD  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/tmr_decode.sv
// Module: address decoder for the timer bank.
// Splits the byte address into timer index and register select, and
// produces one write strobe per timer register. Assumes the address is
// stable while bus_we is high.
module tmr_decode
    import tmr_pkg::*;
#(
    parameter int N_T = NUM_TMR,
    parameter int TW  = TIDX_W,
    parameter int A_W = STRIDE_LSB + TW
) (
    input  logic [A_W-1:0]  addr,
    input  logic            we,
    output logic            hit,
    output logic [TW-1:0]   tidx,
    output reg_sel_e        rsel,
    output logic [N_T-1:0]  wr_cnt,
    output logic [N_T-1:0]  wr_mode,
    output logic [N_T-1:0]  wr_cmp,
    output logic [N_T-1:0]  wr_hold
);
    // Purpose: split the address and check the unused bits.
    always_comb begin
        tidx = addr[STRIDE_LSB +: TW];
        rsel = reg_sel_e'(addr[5:4]);
        hit  = (addr[STRIDE_LSB-1:6] == '0) && (addr[3:0] == 4'd0)
               && (int'(tidx) < N_T);
    end

    // Purpose: produce the per-timer, per-register write strobes.
    always_comb begin
        for (int t = 0; t < N_T; t++) begin
            wr_cnt[t]  = we && hit && (int'(tidx) == t) && (rsel == RG_COUNT);
            wr_mode[t] = we && hit && (int'(tidx) == t) && (rsel == RG_MODE);
            wr_cmp[t]  = we && hit && (int'(tidx) == t) && (rsel == RG_CMP);
            wr_hold[t] = we && hit && (int'(tidx) == t) && (rsel == RG_HOLD);
        end
    end
endmodule

// File: rtl/tmr_channel.sv
// Module: one up-counting timer with compare, overflow, zero-return and
// an optional single-shot disarm. HAS_HOLD selects whether the hold
// register exists. Assumes the write strobes are one-hot per cycle.
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CW       = DW,
    parameter bit HAS_HOLD = 1'b1,
    parameter bit ONE_SHOT = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          wr_cnt,
    input  logic          wr_mode,
    input  logic          wr_cmp,
    input  logic          wr_hold,
    input  logic [CW-1:0] wdata,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] mode_o,
    output logic [CW-1:0] cmp_o,
    output logic [CW-1:0] hold_o,
    output logic          irq_o
);
    logic [3:0]    ctl;
    logic          cflag, oflag;
    logic [CW-1:0] cnt, cmp, hold, cnt_inc;
    logic          advance, hit_cmp, hit_ovf, fire;

    // Purpose: derive this cycle's count step and its events.
    always_comb begin
        cnt_inc = cnt + 1'b1;
        advance = tick && ctl[M_RUN] && !wr_cnt && !wr_mode;
        hit_cmp = advance && ctl[M_CMPE] && (cnt_inc == cmp);
        hit_ovf = advance && ctl[M_OVFE] && (cnt == {CW{1'b1}});
        fire    = hit_cmp || hit_ovf;
    end

    // Purpose: counter register, loaded by the bus or stepped by the tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (wr_cnt)
            cnt <= wdata;
        else if (advance)
            cnt <= (fire && ctl[M_ZRET]) ? '0 : cnt_inc;
    end

    // Purpose: mode controls and sticky flags, including the single-shot disarm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl   <= '0;
            cflag <= 1'b0;
            oflag <= 1'b0;
        end else if (wr_mode) begin
            ctl   <= wdata[3:0];
            cflag <= cflag & ~wdata[M_CFLG];
            oflag <= oflag & ~wdata[M_OFLG];
        end else if (fire) begin
            cflag <= cflag | hit_cmp;
            if (ONE_SHOT) begin
                ctl[M_CMPE] <= 1'b0;
                oflag       <= 1'b0;
            end else begin
                oflag <= oflag | hit_ovf;
            end
        end
    end

    // Purpose: compare and hold registers, plus the registered event pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp   <= '0;
            hold  <= '0;
            irq_o <= 1'b0;
        end else begin
            if (wr_cmp) cmp <= wdata;
            if (wr_hold && HAS_HOLD) hold <= wdata;
            irq_o <= fire;
        end
    end

    // Purpose: present register contents to the read mux.
    always_comb begin
        cnt_o  = cnt;
        cmp_o  = cmp;
        hold_o = HAS_HOLD ? hold : '0;
        mode_o = '0;
        mode_o[3:0]    = ctl;
        mode_o[M_CFLG] = cflag;
        mode_o[M_OFLG] = oflag;
    end

    // R3: a stopped timer without a count write keeps its value
    a_r3_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl[M_RUN] && !wr_cnt) |=> $stable(cnt));

    // R7: a pulse follows a tick taken while counting
    a_r7_irq_from_tick: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($past(tick) && $past(ctl[M_RUN])));

    // R8: zero-return leaves the counter at zero on the pulse cycle
    a_r8_zret_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && ctl[M_ZRET]) |-> (cnt == '0));

    // R9: single-shot timers are disarmed once they have fired
    if (ONE_SHOT) begin : g_oneshot_chk
        a_r9_oneshot_disarm: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o |-> (!ctl[M_CMPE] && !oflag));
    end else begin : g_armed_chk
        a_r9_keeps_armed: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_o && $past(ctl[M_CMPE])) |-> ctl[M_CMPE]);
    end
endmodule

// File: rtl/tmr_quad.sv
// Module: top of the four-timer bank. Decodes the register port, builds
// one channel per timer (hold only on the low N_HOLD timers, single-shot
// on all but timer 0) and muxes read data. Reads have no side effects.
module tmr_quad
    import tmr_pkg::*;
#(
    parameter int N_T    = NUM_TMR,
    parameter int N_HOLD = 2,
    parameter int D_W    = DW,
    parameter int TW     = $clog2(N_T),
    parameter int A_W    = STRIDE_LSB + TW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick_i,
    input  logic [A_W-1:0] bus_addr_i,
    input  logic [D_W-1:0] bus_wdata_i,
    input  logic           bus_we_i,
    output logic [D_W-1:0] bus_rdata_o,
    output logic [N_T-1:0] irq_o
);
    logic           hit;
    logic [TW-1:0]  tidx;
    reg_sel_e       rsel;
    logic [N_T-1:0] wr_cnt, wr_mode, wr_cmp, wr_hold;
    logic [D_W-1:0] cnt_v [N_T];
    logic [D_W-1:0] mode_v[N_T];
    logic [D_W-1:0] cmp_v [N_T];
    logic [D_W-1:0] hold_v[N_T];

    tmr_decode #(.N_T(N_T), .TW(TW), .A_W(A_W)) u_dec (
        .addr(bus_addr_i), .we(bus_we_i), .hit(hit), .tidx(tidx), .rsel(rsel),
        .wr_cnt(wr_cnt), .wr_mode(wr_mode), .wr_cmp(wr_cmp), .wr_hold(wr_hold)
    );

    for (genvar i = 0; i < N_T; i++) begin : g_tmr
        tmr_channel #(
            .CW(D_W),
            .HAS_HOLD(i < N_HOLD),
            .ONE_SHOT(i != 0)
        ) u_ch (
            .clk(clk), .rst_n(rst_n), .tick(tick_i),
            .wr_cnt(wr_cnt[i]), .wr_mode(wr_mode[i]),
            .wr_cmp(wr_cmp[i]), .wr_hold(wr_hold[i]),
            .wdata(bus_wdata_i),
            .cnt_o(cnt_v[i]), .mode_o(mode_v[i]),
            .cmp_o(cmp_v[i]), .hold_o(hold_v[i]),
            .irq_o(irq_o[i])
        );
    end

    // Purpose: select read data for the addressed timer register.
    always_comb begin
        bus_rdata_o = '0;
        if (hit) begin
            case (rsel)
                RG_COUNT: bus_rdata_o = cnt_v[tidx];
                RG_MODE:  bus_rdata_o = mode_v[tidx];
                RG_CMP:   bus_rdata_o = cmp_v[tidx];
                default:  bus_rdata_o = hold_v[tidx];
            endcase
        end
    end

    // R1: an address outside the register windows reads as zero
    a_r1_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_i[3:0] != 4'd0) |-> (bus_rdata_o == '0));

    // R10: hold offset of a timer without a hold register reads zero
    a_r10_no_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && rsel == RG_HOLD && int'(tidx) >= N_HOLD) |-> (bus_rdata_o == '0));

    // R2: interrupt lines are low in the first cycle after reset
    a_r2_irq_reset: assert property (@(posedge clk)
        $past(!rst_n) |-> (irq_o == '0));
endmodule

// File: tb/tmr_quad_test.sv
// Bench: table of register operations walked by one loop, then directed
// checks for reset, interrupts, single-shot, overflow and write priority.
module tmr_quad_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [12:0] addr = '0;
    logic [15:0] wdata = '0;
    logic        we = 1'b0;
    logic [15:0] rdata;
    logic [3:0]  irq;
    int nvec = 0;
    int nfail = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    tmr_quad uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_we_i(we), .bus_rdata_o(rdata), .irq_o(irq)
    );

    // {kind[1:0], addr[12:0], data[15:0]}; kind 0 write, 1 read-check, 2 ticks
    localparam int NV = 26;
    localparam logic [30:0] VEC [NV] = '{
        {2'd0, 13'h0020, 16'h0003},  // R5 T0 compare 3
        {2'd0, 13'h0010, 16'h0007},  // R3 run+zret+cmpe
        {2'd2, 13'h0000, 16'd1},
        {2'd1, 13'h0000, 16'h0001},  // R3 counted once
        {2'd2, 13'h0000, 16'd2},
        {2'd1, 13'h0000, 16'h0000},  // R8 returned to zero
        {2'd1, 13'h0010, 16'h0407},  // R7 compare flag
        {2'd0, 13'h0010, 16'h0400},  // R11 W1C and stop
        {2'd1, 13'h0010, 16'h0000},  // R11
        {2'd2, 13'h0000, 16'd3},
        {2'd1, 13'h0000, 16'h0000},  // R3 stopped
        {2'd0, 13'h0800, 16'hFFFE},  // R4 T1 load
        {2'd1, 13'h0800, 16'hFFFE},  // R4
        {2'd0, 13'h0810, 16'h0009},  // R6 run+ovfe
        {2'd2, 13'h0000, 16'd2},
        {2'd1, 13'h0800, 16'h0000},  // R6 wrapped
        {2'd1, 13'h0810, 16'h0009},  // R9 overflow flag cleared on T1
        {2'd0, 13'h1030, 16'hABCD},  // R10 T2 hold write
        {2'd1, 13'h1030, 16'h0000},  // R10
        {2'd0, 13'h0830, 16'h1234},  // R10 T1 hold
        {2'd1, 13'h0830, 16'h1234},  // R10
        {2'd0, 13'h1048, 16'h5555},  // R1 unmapped
        {2'd1, 13'h1048, 16'h0000},  // R1
        {2'd0, 13'h1820, 16'h00A5},  // R1 T3 compare
        {2'd1, 13'h1820, 16'h00A5},  // R1
        {2'd1, 13'h1020, 16'h0000}   // R1 T2 compare untouched
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [12:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [12:0] a, output logic [15:0] d);
        @(negedge clk);
        addr = a;
        #2 d = rdata;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R2 reset state
        for (int t = 0; t < 4; t++)
            for (int r = 0; r < 4; r++) begin
                rd(13'((t << 11) | (r << 4)), v);
                chk("R2", v, 16'h0000);
            end
        chk("R2 irq", {12'h0, irq}, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            case (VEC[i][30:29])
                2'd0: wr(VEC[i][28:16], VEC[i][15:0]);
                2'd1: begin
                    rd(VEC[i][28:16], v);
                    chk($sformatf("vector %0d", i), v, VEC[i][15:0]);
                end
                default: ticks(int'(VEC[i][15:0]));
            endcase
        end

        // R5 R9 single-shot on T2: compare 2, run+cmpe
        wr(13'h1020, 16'h0002);
        wr(13'h1010, 16'h0005);
        ticks(1);
        chk("R5 no early irq", {12'h0, irq}, 16'h0000);
        ticks(1);
        chk("R7 T2 pulse", {12'h0, irq}, 16'h0004);
        @(negedge clk);
        chk("R7 pulse one cycle", {12'h0, irq}, 16'h0000);
        rd(13'h1010, v);
        chk("R9 T2 disarmed", v, 16'h0401);
        wr(13'h1000, 16'h0001);
        ticks(1);
        chk("R9 T2 no refire", {12'h0, irq}, 16'h0000);

        // R9 timer 0 stays armed: compare 2, run+zret+cmpe
        wr(13'h0000, 16'h0000);
        wr(13'h0020, 16'h0002);
        wr(13'h0010, 16'h0007);
        ticks(2);
        chk("R9 T0 first", {12'h0, irq}, 16'h0001);
        ticks(2);
        chk("R9 T0 again", {12'h0, irq}, 16'h0001);
        rd(13'h0010, v);
        chk("R9 T0 armed", v, 16'h0407);

        // R4 count write beats a simultaneous tick
        @(negedge clk);
        addr = 13'h0000; wdata = 16'h0010; we = 1'b1; tick = 1'b1;
        @(negedge clk);
        we = 1'b0; tick = 1'b0;
        rd(13'h0000, v);
        chk("R4 write priority", v, 16'h0010);

        // R6 R7 overflow on T0 sets bit 11
        wr(13'h0000, 16'hFFFF);
        wr(13'h0010, 16'h0009);
        ticks(1);
        chk("R6 T0 overflow pulse", {12'h0, irq}, 16'h0001);
        rd(13'h0010, v);
        chk("R7 overflow flag", v, 16'h0C09);
        rd(13'h0000, v);
        chk("R6 wrapped", v, 16'h0000);
        wr(13'h0010, 16'h0800);
        rd(13'h0010, v);
        chk("R11 clear only bit 11", v, 16'h0400);

        // R2 reset mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(13'h0830, v);
        chk("R2 hold after reset", v, 16'h0000);
        rd(13'h1820, v);
        chk("R2 compare after reset", v, 16'h0000);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule